// File: doc/BRIEF.md
# Interrupt-Triggered Cache Freeze Controller

This block keeps the control word for a pair of caches, one for instructions and one for data. Each cache has a two-bit state field and a freeze-on-interrupt enable bit. Software sets and reads the word through a simple write/read port. The caches follow the two state outputs.

When the processor acknowledges an interrupt, the block registers the acknowledgment and passes it on, together with the interrupt number, to the interrupt controller. On the same clock edge, each cache whose enable bit is set and whose state is "enabled" drops to "frozen". States other than enabled are left alone. A frozen cache stays frozen until software writes a new state, so any unfreeze policy belongs to software.

Top module: `cache_freeze_ctrl`

## Requirements
- R1: After reset the control word is all zeros. Both state outputs read 00 and the acknowledge output is low.
- R2: A write stores bits 5:0 of the write data into the control word. Read data shows the whole control word at all times, and bits REG_W-1:6 always read as zero.
- R3: The state encodings are 00 disabled, 01 frozen, 11 enabled and 10 reserved. The instruction state sits in bits 1:0, the data state in bits 3:2, the instruction freeze enable in bit 4 and the data freeze enable in bit 5. Each state output mirrors its field.
- R4: On an acknowledge with bit 4 set and an instruction state of 11, the instruction state is 01 from the next cycle on.
- R5: On an acknowledge with bit 5 set and a data state of 11, the data state is 01 from the next cycle on.
- R6: On an acknowledge, a cache whose freeze enable bit is clear keeps its state.
- R7: On an acknowledge, a cache whose state is 00, 01 or 10 keeps that state.
- R8: Each cycle with the acknowledge input high produces the acknowledge output high in the next cycle, carrying that cycle's interrupt number. The acknowledge output is never high without an acknowledge one cycle earlier.
- R9: When a write and an acknowledge fall in the same cycle, the freeze rule is applied to the newly written enable bits and states.
- R10: In a cycle with neither a write nor an acknowledge, the control word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | REG_W | Write data |
| reg_rd_data | output | REG_W | Current control word |
| irq_ack_valid | input | 1 | Interrupt acknowledge from the processor |
| irq_ack_num | input | NUM_W | Number of the acknowledged interrupt |
| ctl_ack_valid | output | 1 | Acknowledge forwarded to the interrupt controller |
| ctl_ack_num | output | NUM_W | Interrupt number sent with the forwarded acknowledge |
| icache_state | output | 2 | Instruction cache state |
| dcache_state | output | 2 | Data cache state |

## Verification
The bench targets the cycle where a write and an acknowledge coincide. A design that tested the old word would freeze a cache that software had just disabled, or fail to freeze one it had just enabled. It also sends acknowledges while the states are frozen, disabled or set to the reserved code 10. A design that matched loosely on the top state bit would corrupt 10, and one that always forced 01 would turn a disabled cache on. Setting one freeze enable without the other catches crossed bit positions between the two lanes. A long random run is compared against the behavioural model on every clock, which exposes any late or missing forwarded acknowledge and any stray change to the word.

// File: rtl/cfz_pkg.sv
package cfz_pkg;

   localparam int NCACHE   = 2;
   localparam int IMPL_W   = 6;
   localparam int STATE_W  = 2;

   typedef enum logic [STATE_W-1:0] {
      CS_OFF    = 2'b00,
      CS_FROZEN = 2'b01,
      CS_RSVD   = 2'b10,
      CS_ON     = 2'b11
   } cache_state_e;

   // lane 0 = instruction cache, lane 1 = data cache
   function automatic int state_lsb(input int lane);
      return lane * STATE_W;
   endfunction

   function automatic int enable_bit(input int lane);
      return NCACHE * STATE_W + lane;
   endfunction

endpackage

// File: rtl/cfz_write_merge.sv
module cfz_write_merge #(
   parameter int REG_W = 32
) (
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic [REG_W-1:0] cur_word,
   output logic [REG_W-1:0] pre_word
);
   import cfz_pkg::*;

   localparam logic [REG_W-1:0] IMPL_MASK = REG_W'((1 << IMPL_W) - 1);

   always_comb begin
      if (wr_en) pre_word = wr_data & IMPL_MASK;
      else       pre_word = cur_word;
   end

endmodule

// File: rtl/cfz_freeze_lane.sv
module cfz_freeze_lane
   import cfz_pkg::*;
#(
   parameter int LANE = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ack,
   input  logic               fe_pre,
   input  logic [STATE_W-1:0] state_pre,
   input  logic [STATE_W-1:0] state_cur,
   output logic [STATE_W-1:0] state_nxt
);

   always_comb begin
      state_nxt = state_pre;
      if (ack && fe_pre && (state_pre == CS_ON))
         state_nxt = CS_FROZEN;
   end

   generate
      if (LANE == 0) begin : g_ilane
         AST_IFREEZE: assert property (@(posedge clk) disable iff (!rst_n)
            (ack && fe_pre && state_pre == CS_ON) |=> (state_cur == CS_FROZEN)); // R4
      end else begin : g_dlane
         AST_DFREEZE: assert property (@(posedge clk) disable iff (!rst_n)
            (ack && fe_pre && state_pre == CS_ON) |=> (state_cur == CS_FROZEN)); // R5
      end
   endgenerate

   AST_FE_OFF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !fe_pre) |=> (state_cur == $past(state_pre))); // R6

   AST_NOT_ON_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && state_pre != CS_ON) |=> (state_cur == $past(state_pre))); // R7

endmodule

// File: rtl/cfz_ack_relay.sv
module cfz_ack_relay #(
   parameter int NUM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_in,
   input  logic [NUM_W-1:0] num_in,
   output logic             ack_out,
   output logic [NUM_W-1:0] num_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_out <= 1'b0;
         num_out <= '0;
      end else begin
         ack_out <= ack_in;
         if (ack_in) num_out <= num_in;
      end
   end

   AST_ACK_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      ack_in |=> (ack_out && num_out == $past(num_in))); // R8

   AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_in |=> !ack_out); // R8

endmodule

// File: rtl/cache_freeze_ctrl.sv
module cache_freeze_ctrl
   import cfz_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int NUM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_en,
   input  logic [REG_W-1:0] reg_wr_data,
   output logic [REG_W-1:0] reg_rd_data,
   input  logic             irq_ack_valid,
   input  logic [NUM_W-1:0] irq_ack_num,
   output logic             ctl_ack_valid,
   output logic [NUM_W-1:0] ctl_ack_num,
   output logic [1:0]       icache_state,
   output logic [1:0]       dcache_state
);

   generate
      if (REG_W < IMPL_W) begin : g_bad_reg_w
         $error("REG_W must be at least IMPL_W");
      end
      if (NUM_W < 1) begin : g_bad_num_w
         $error("NUM_W must be at least 1");
      end
   endgenerate

   logic [REG_W-1:0]   ctl_q;
   logic [REG_W-1:0]   pre_word;
   logic [REG_W-1:0]   nxt_word;
   logic [STATE_W-1:0] lane_nxt [NCACHE];

   cfz_write_merge #(.REG_W(REG_W)) i_merge (
      .wr_en    (reg_wr_en),
      .wr_data  (reg_wr_data),
      .cur_word (ctl_q),
      .pre_word (pre_word)
   );

   for (genvar g = 0; g < NCACHE; g++) begin : g_lane
      localparam int LSB = state_lsb(g);
      localparam int FEB = enable_bit(g);
      cfz_freeze_lane #(.LANE(g)) i_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .ack       (irq_ack_valid),
         .fe_pre    (pre_word[FEB]),
         .state_pre (pre_word[LSB +: STATE_W]),
         .state_cur (ctl_q[LSB +: STATE_W]),
         .state_nxt (lane_nxt[g])
      );
   end

   always_comb begin
      nxt_word = pre_word;
      for (int k = 0; k < NCACHE; k++)
         nxt_word[k*STATE_W +: STATE_W] = lane_nxt[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= '0;
      else        ctl_q <= nxt_word;
   end

   cfz_ack_relay #(.NUM_W(NUM_W)) i_relay (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack_in  (irq_ack_valid),
      .num_in  (irq_ack_num),
      .ack_out (ctl_ack_valid),
      .num_out (ctl_ack_num)
   );

   assign reg_rd_data  = ctl_q;
   assign icache_state = ctl_q[state_lsb(0) +: STATE_W];
   assign dcache_state = ctl_q[state_lsb(1) +: STATE_W];

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr_en && !irq_ack_valid) |=> $stable(reg_rd_data)); // R10

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_data[REG_W-1:IMPL_W] == '0); // R2

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && !irq_ack_valid) |=> (reg_rd_data[IMPL_W-1:0] == $past(reg_wr_data[IMPL_W-1:0]))); // R2

   AST_WRITE_THEN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && irq_ack_valid && reg_wr_data[4] && reg_wr_data[1:0] == 2'b11)
      |=> (icache_state == 2'b01)); // R9

endmodule

// File: tb/test_cache_freeze_ctrl.sv
module test_cache_freeze_ctrl;

   localparam int REG_W = 32;
   localparam int NUM_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr_en = 1'b0;
   logic [REG_W-1:0] reg_wr_data = '0;
   logic [REG_W-1:0] reg_rd_data;
   logic             irq_ack_valid = 1'b0;
   logic [NUM_W-1:0] irq_ack_num = '0;
   logic             ctl_ack_valid;
   logic [NUM_W-1:0] ctl_ack_num;
   logic [1:0]       icache_state;
   logic [1:0]       dcache_state;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   logic [31:0] m_word = '0;
   bit          m_ack  = 0;
   logic [7:0]  m_num  = '0;

   always #10 clk = ~clk;

   cache_freeze_ctrl #(.REG_W(REG_W), .NUM_W(NUM_W)) i_cache_freeze_ctrl (
      .clk, .rst_n, .reg_wr_en, .reg_wr_data, .reg_rd_data,
      .irq_ack_valid, .irq_ack_num, .ctl_ack_valid, .ctl_ack_num,
      .icache_state, .dcache_state
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      check(reg_rd_data == m_word, {tag, " word"}, reg_rd_data, m_word);
      check(icache_state == m_word[1:0], {tag, " R3 istate"}, icache_state, m_word[1:0]);
      check(dcache_state == m_word[3:2], {tag, " R3 dstate"}, dcache_state, m_word[3:2]);
      check(ctl_ack_valid == m_ack, {tag, " R8 ack"}, ctl_ack_valid, m_ack);
      if (m_ack) check(ctl_ack_num == m_num, {tag, " R8 num"}, ctl_ack_num, m_num);
   endtask

   // behavioural reference: written value first, then freeze per cache
   task automatic model_update(input bit wr, input logic [31:0] wd, input bit ack, input logic [7:0] num);
      if (wr) m_word = wd & 32'h3F;
      if (ack) begin
         if (m_word[4] && m_word[1:0] == 2'b11) m_word[1:0] = 2'b01;
         if (m_word[5] && m_word[3:2] == 2'b11) m_word[3:2] = 2'b01;
         m_num = num;
      end
      m_ack = ack;
   endtask

   task automatic step(input bit wr, input logic [31:0] wd, input bit ack, input logic [7:0] num, input string tag);
      reg_wr_en     = wr;
      reg_wr_data   = wd;
      irq_ack_valid = ack;
      irq_ack_num   = num;
      @(posedge clk);
      model_update(wr, wd, ack, num);
      @(negedge clk);
      compare_all(tag);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare_all("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1 after release");

      step(1, 32'hFFFF_FFFF, 0, 8'h00, "R2 write all ones");
      step(0, 32'h0, 0, 8'h00, "R10 idle");
      step(0, 32'h0, 1, 8'h05, "R4 R5 freeze both");
      step(0, 32'h0, 1, 8'h0A, "R7 already frozen");
      step(0, 32'h0, 0, 8'h00, "R8 no stray ack");
      step(1, 32'h0000_000F, 0, 8'h00, "R2 enables off");
      step(0, 32'h0, 1, 8'h11, "R6 enables clear");
      step(1, 32'h0000_001F, 0, 8'h00, "R2 ife only");
      step(0, 32'h0, 1, 8'h22, "R4 R6 instruction only");
      step(1, 32'h0000_002F, 0, 8'h00, "R2 dfe only");
      step(0, 32'h0, 1, 8'h33, "R5 R6 data only");
      step(1, 32'h0000_003A, 0, 8'h00, "R3 reserved code");
      step(0, 32'h0, 1, 8'h44, "R7 reserved kept");
      step(1, 32'h0000_0030, 0, 8'h00, "R2 both disabled");
      step(0, 32'h0, 1, 8'h55, "R7 disabled kept");
      step(1, 32'h0000_003F, 1, 8'h66, "R9 write with ack");
      step(1, 32'h0000_002F, 1, 8'h77, "R9 write with ack dfe");
      step(1, 32'hABCD_0013, 1, 8'h88, "R9 R2 upper bits dropped");
      step(0, 32'h0, 1, 8'h99, "R8 back to back ack");

      for (int i = 0; i < 3000; i++) begin
         step($urandom_range(0, 3) == 0, $urandom, $urandom_range(0, 2) == 0,
              8'($urandom), "R10 random");
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule